// File: doc/BRIEF.md
# Load and Store Byte-Lane Aligner

This block sits between the integer core of a 32-bit processor and a data memory organised as 32-bit little-endian words. On a load it takes the whole memory word and the two low bits of the effective address. It picks out the byte, halfword or word being accessed and extends it to 32 bits, with sign or zero fill, to give the value written back to the destination register. On a store it takes the source register value. It places the byte or halfword into every lane that could be written and raises the byte-write enables for the lanes the access covers.

The effective address is computed upstream. Only its two low bits enter here. An access whose offset does not match its size is flagged as misaligned. In that case no lane is enabled and the load result is forced to zero. All results are captured in one output register stage, so they reach the ports one clock after the request is presented.

Top module: `lsu_lane_aligner`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs become zero at that edge.
- R2: Each result reflects the inputs sampled at the previous rising edge, so there is exactly one cycle of latency.
- R3: Access size encoding on `acc_size` is 2'b00 byte, 2'b01 halfword, 2'b10 and 2'b11 word. For a byte load with `ld_unsigned`=0, `load_data` is memory byte `addr_lo` (bits 8*addr_lo+7 down to 8*addr_lo) sign-extended from its bit 7.
- R4: For a byte load with `ld_unsigned`=1, the same byte is zero-extended, so `load_data[31:8]` is zero.
- R5: For an aligned halfword load (`addr_lo[0]`=0), `load_data` is the memory half selected by `addr_lo[1]` (0 low half, 1 high half). It is sign-extended when `ld_unsigned`=0 and zero-extended when `ld_unsigned`=1.
- R6: For an aligned word load (`addr_lo`=0), `load_data` equals `mem_rdata` unchanged.
- R7: For a byte store, `store_wdata` holds `store_src[7:0]` in all four byte lanes, and `byte_en` is 4'b0001 shifted left by `addr_lo`.
- R8: For an aligned halfword store, `store_wdata` holds `store_src[15:0]` in both halves, and `byte_en` is 4'b0011 when `addr_lo[1]`=0 or 4'b1100 when `addr_lo[1]`=1.
- R9: For an aligned word store, `store_wdata` equals `store_src` and `byte_en` is 4'b1111.
- R10: A halfword access with `addr_lo[0]`=1, or a word access with a non-zero `addr_lo`, sets `misaligned`. It drives `byte_en` to 4'b0000 and `load_data` to zero.
- R11: When `is_store`=0, `byte_en` is 4'b0000 whatever the size and offset.
- R12: A byte access is never misaligned at any of the four offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_store | input | 1 | 1 for a store request, 0 for a load |
| acc_size | input | 2 | Access size code (see R3) |
| ld_unsigned | input | 1 | Zero-extend loaded byte or halfword |
| addr_lo | input | 2 | Low two bits of the effective address |
| mem_rdata | input | 32 | Word read from data memory |
| store_src | input | 32 | Source register value for a store |
| load_data | output | 32 | Extended load result |
| store_wdata | output | 32 | Lane-steered store data |
| byte_en | output | 4 | Byte-write enables, bit n for bits 8n+7..8n |
| misaligned | output | 1 | Offset does not suit the access size |

## Verification
Every result of this block is due one rising edge after the request that produced it. No output needs more than that single edge. The driver sets a request half a period before an edge and queues the expected load value, store word, enables and flag. The monitor samples one nanosecond after the next edge and takes exactly one queued item per edge. A check can therefore neither read a result that is not yet registered nor read a stale one. The reset values are sampled while `rst` is still held high, with non-zero inputs applied.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int OFS_W  = $clog2(LANES);
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [DATA_W-1:0] load_data;
        logic [DATA_W-1:0] store_wdata;
        logic [LANES-1:0]  byte_en;
        logic              misaligned;
    } align_rsp_t;

    function automatic logic is_word(acc_size_e sz);
        return sz[1];
    endfunction

    function automatic logic offset_bad(acc_size_e sz, logic [OFS_W-1:0] ofs);
        logic bad;
        if (is_word(sz))        bad = (ofs != '0);
        else if (sz == SZ_HALF) bad = ofs[0];
        else                    bad = 1'b0;
        return bad;
    endfunction

endpackage

// File: rtl/lsu_misalign_detect.sv
module lsu_misalign_detect
    import lsu_align_pkg::*;
(
    input  acc_size_e        size_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic             bad_o
);
    always_comb begin
        bad_o = offset_bad(size_i, ofs_i);
    end
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend
    import lsu_align_pkg::*;
(
    input  acc_size_e         size_i,
    input  logic              zext_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              bad_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o
);
    logic [7:0]        sel_byte;
    logic [HALF_W-1:0] sel_half;
    logic              fill;

    always_comb begin
        sel_byte = word_i[{ofs_i, 3'b000} +: 8];
        sel_half = word_i[{ofs_i[OFS_W-1], 4'b0000} +: HALF_W];
        data_o   = '0;
        fill     = 1'b0;
        if (bad_i) begin
            data_o = '0;
        end else if (is_word(size_i)) begin
            data_o = word_i;
        end else if (size_i == SZ_HALF) begin
            fill   = ~zext_i & sel_half[HALF_W-1];
            data_o = {{(DATA_W-HALF_W){fill}}, sel_half};
        end else begin
            fill   = ~zext_i & sel_byte[7];
            data_o = {{(DATA_W-8){fill}}, sel_byte};
        end
    end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
    import lsu_align_pkg::*;
(
    input  acc_size_e         size_i,
    input  logic              write_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              bad_i,
    input  logic [DATA_W-1:0] src_i,
    output logic [DATA_W-1:0] wdata_o,
    output logic [LANES-1:0]  en_o
);
    always_comb begin
        if (is_word(size_i))        wdata_o = src_i;
        else if (size_i == SZ_HALF) wdata_o = {(DATA_W/HALF_W){src_i[HALF_W-1:0]}};
        else                        wdata_o = {LANES{src_i[7:0]}};
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic covers;
        always_comb begin
            if (is_word(size_i))
                covers = 1'b1;
            else if (size_i == SZ_HALF)
                covers = (ofs_i[OFS_W-1] == ln[OFS_W-1]);
            else
                covers = (ofs_i == ln[OFS_W-1:0]);
            en_o[ln] = write_i & ~bad_i & covers;
        end
    end
endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
    import lsu_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              is_store,
    input  logic [1:0]        acc_size,
    input  logic              ld_unsigned,
    input  logic [OFS_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] store_src,
    output logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] store_wdata,
    output logic [LANES-1:0]  byte_en,
    output logic              misaligned
);
    acc_size_e  size_c;
    align_rsp_t rsp_d, rsp_q;
    logic       bad_w;

    assign size_c = acc_size_e'(acc_size);

    lsu_misalign_detect u_detect (
        .size_i (size_c),
        .ofs_i  (addr_lo),
        .bad_o  (bad_w)
    );

    lsu_load_extend u_load (
        .size_i (size_c),
        .zext_i (ld_unsigned),
        .ofs_i  (addr_lo),
        .bad_i  (bad_w),
        .word_i (mem_rdata),
        .data_o (rsp_d.load_data)
    );

    lsu_store_steer u_store (
        .size_i  (size_c),
        .write_i (is_store),
        .ofs_i   (addr_lo),
        .bad_i   (bad_w),
        .src_i   (store_src),
        .wdata_o (rsp_d.store_wdata),
        .en_o    (rsp_d.byte_en)
    );

    assign rsp_d.misaligned = bad_w;

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign load_data   = rsp_q.load_data;
    assign store_wdata = rsp_q.store_wdata;
    assign byte_en     = rsp_q.byte_en;
    assign misaligned  = rsp_q.misaligned;
endmodule

// File: rtl/lsu_lane_aligner_sva.sv
module lsu_lane_aligner_sva
    import lsu_align_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              is_store,
    input logic [1:0]        acc_size,
    input logic              ld_unsigned,
    input logic [OFS_W-1:0]  addr_lo,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] store_src,
    input logic [DATA_W-1:0] load_data,
    input logic [DATA_W-1:0] store_wdata,
    input logic [LANES-1:0]  byte_en,
    input logic              misaligned
);
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= !rst;

    // R10
    misaligned_quiet_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        misaligned |-> (byte_en == '0 && load_data == '0));

    // R7
    byte_store_single_lane_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(is_store && acc_size == 2'b00) |->
            ($countones(byte_en) == 1 && store_wdata[DATA_W-1 -: 8] == $past(store_src[7:0])));

    // R9
    word_store_full_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(is_store && acc_size[1] && addr_lo == '0) |->
            (byte_en == '1 && store_wdata == $past(store_src)));

    // R6
    word_load_pass_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(acc_size[1] && addr_lo == '0) |-> load_data == $past(mem_rdata));

    // R11
    load_no_write_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(!is_store) |-> byte_en == '0);

    // R4
    ubyte_zero_fill_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(acc_size == 2'b00 && ld_unsigned) |-> load_data[DATA_W-1:8] == '0);

    // R12
    byte_never_bad_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(acc_size == 2'b00) |-> !misaligned);
endmodule

bind lsu_lane_aligner lsu_lane_aligner_sva i_sva (
    .clk         (clk),
    .rst         (rst),
    .is_store    (is_store),
    .acc_size    (acc_size),
    .ld_unsigned (ld_unsigned),
    .addr_lo     (addr_lo),
    .mem_rdata   (mem_rdata),
    .store_src   (store_src),
    .load_data   (load_data),
    .store_wdata (store_wdata),
    .byte_en     (byte_en),
    .misaligned  (misaligned)
);

// File: tb/test_lsu_lane_aligner.sv
module test_lsu_lane_aligner;

    typedef struct {
        logic [31:0] ld;
        logic [31:0] wd;
        logic [3:0]  en;
        logic        mis;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        is_store = 1'b0;
    logic [1:0]  acc_size = 2'b00;
    logic        ld_unsigned = 1'b0;
    logic [1:0]  addr_lo = 2'b00;
    logic [31:0] mem_rdata = 32'h0;
    logic [31:0] store_src = 32'h0;
    logic [31:0] load_data, store_wdata;
    logic [3:0]  byte_en;
    logic        misaligned;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #4 clk = ~clk;

    lsu_lane_aligner i_lsu_lane_aligner (
        .clk, .rst, .is_store, .acc_size, .ld_unsigned, .addr_lo,
        .mem_rdata, .store_src, .load_data, .store_wdata, .byte_en, .misaligned
    );

    function automatic exp_t model(logic st, logic [1:0] sz, logic u, logic [1:0] a,
                                   logic [31:0] m, logic [31:0] s, string tag);
        exp_t e;
        logic [7:0]  b;
        logic [15:0] h;
        b = 8'((m >> (a * 8)) & 32'hFF);
        h = a[1] ? m[31:16] : m[15:0];
        e.tag = tag;
        case (sz)
            2'b00: e.mis = 1'b0;
            2'b01: e.mis = a[0];
            default: e.mis = (a != 2'b00);
        endcase
        case (sz)
            2'b00: e.ld = u ? {24'h0, b} : {{24{b[7]}}, b};
            2'b01: e.ld = u ? {16'h0, h} : {{16{h[15]}}, h};
            default: e.ld = m;
        endcase
        case (sz)
            2'b00: begin e.wd = {s[7:0], s[7:0], s[7:0], s[7:0]}; e.en = 4'b0001 << a; end
            2'b01: begin e.wd = {s[15:0], s[15:0]}; e.en = a[1] ? 4'b1100 : 4'b0011; end
            default: begin e.wd = s; e.en = 4'b1111; end
        endcase
        if (e.mis) begin e.ld = 32'h0; e.en = 4'b0000; end
        if (!st) e.en = 4'b0000;
        return e;
    endfunction

    task automatic drive(logic st, logic [1:0] sz, logic u, logic [1:0] a,
                         logic [31:0] m, logic [31:0] s, string tag);
        @(negedge clk);
        is_store = st; acc_size = sz; ld_unsigned = u; addr_lo = a;
        mem_rdata = m; store_src = s;
        q.push_back(model(st, sz, u, a, m, s, tag));
    endtask

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: one result due per rising edge (R2)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "load_data", load_data, e.ld);
                cmp(e.tag, "store_wdata", store_wdata, e.wd);
                cmp(e.tag, "byte_en", {28'h0, byte_en}, {28'h0, e.en});
                cmp(e.tag, "misaligned", {31'h0, misaligned}, {31'h0, e.mis});
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    localparam logic [31:0] MEM = 32'h80FF7F01;
    localparam logic [31:0] SRC = 32'hDEADBEA5;

    initial begin
        // R1: reset with busy inputs
        is_store = 1'b1; acc_size = 2'b10; mem_rdata = MEM; store_src = SRC;
        repeat (3) @(posedge clk);
        #1;
        cmp("R1", "load_data", load_data, 32'h0);
        cmp("R1", "store_wdata", store_wdata, 32'h0);
        cmp("R1", "byte_en", {28'h0, byte_en}, 32'h0);
        cmp("R1", "misaligned", {31'h0, misaligned}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R3 signed byte loads, R12 every offset
        for (int a = 0; a < 4; a++) drive(0, 2'b00, 0, 2'(a), MEM, SRC, "R3_R12");
        drive(0, 2'b00, 0, 2'd1, 32'h12345678, SRC, "R3");
        // R4 unsigned byte loads
        drive(0, 2'b00, 1, 2'd3, MEM, SRC, "R4");
        drive(0, 2'b00, 1, 2'd2, MEM, SRC, "R4");
        // R5 halfword loads
        drive(0, 2'b01, 0, 2'd0, MEM, SRC, "R5");
        drive(0, 2'b01, 0, 2'd2, MEM, SRC, "R5");
        drive(0, 2'b01, 1, 2'd2, MEM, SRC, "R5");
        // R6 word loads, both word codes
        drive(0, 2'b10, 0, 2'd0, MEM, SRC, "R6");
        drive(0, 2'b11, 1, 2'd0, 32'hCAFEF00D, SRC, "R6");
        // R10 misaligned loads
        drive(0, 2'b01, 0, 2'd1, MEM, SRC, "R10");
        drive(0, 2'b10, 0, 2'd2, MEM, SRC, "R10");
        drive(0, 2'b10, 0, 2'd3, MEM, SRC, "R10");
        // R7 byte stores at every offset, R12
        for (int a = 0; a < 4; a++) drive(1, 2'b00, 0, 2'(a), MEM, SRC, "R7_R12");
        // R8 halfword stores
        drive(1, 2'b01, 0, 2'd0, MEM, SRC, "R8");
        drive(1, 2'b01, 0, 2'd2, MEM, 32'h00018001, "R8");
        // R9 word stores
        drive(1, 2'b10, 0, 2'd0, MEM, SRC, "R9");
        drive(1, 2'b11, 0, 2'd0, MEM, 32'h0F0F1234, "R9");
        // R10 misaligned stores
        drive(1, 2'b01, 0, 2'd3, MEM, SRC, "R10");
        drive(1, 2'b10, 0, 2'd1, MEM, SRC, "R10");
        // R11 loads never write
        drive(0, 2'b10, 0, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R11");
        drive(0, 2'b01, 0, 2'd2, MEM, SRC, "R11");
        // R2 back-to-back changes after a store
        drive(1, 2'b00, 0, 2'd2, 32'h0, 32'h0000003C, "R2");
        drive(0, 2'b00, 0, 2'd0, 32'h000000F0, 32'h0, "R2");

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule